// File: doc/BRIEF.md
# Multi-Mode Position Counter for Quadrature and Pulse Inputs

This block keeps one unsigned position count driven by two asynchronous input lines, A and B. A function code chosen at run time decides how line activity becomes count steps. There are plain increase and decrease functions, a step-and-direction function, and five quadrature decoders:
- single-edge decoding on A or on B;
- two-edge decoding on A or on B;
- full four-edge decoding.

Both lines are synchronized and edge-detected inside the block. The count can be cleared or loaded at any time. The block also reports the current decoded direction, the synchronized line levels, and a sticky flag for invalid quadrature transitions.

A typical use is behind a rotary or linear encoder, where the four-edge decoder gives full resolution. The same block can be switched to a step/direction interface or to plain event tallying without changing the wiring.

Top module: `qcnt_top`

## Requirements
- R1: After reset, count_o is 0, dir_o is 1 (forward), err_o is 0, and both level outputs are 0.
- R2: Each line passes through two synchronizing flops. level_a_o and level_b_o follow a line change two clock edges later. Any count step caused by that change appears on the third edge.
- R3: Function code 7 (four-edge quadrature) counts every single-line transition on either line, up when forward and down when backward.
- R4: Function codes 5 (two-edge on A) and 6 (two-edge on B) count every transition of the chosen line. The decoded direction sets the sign, and the other line never counts.
- R5: Function codes 3 (single-edge on A) and 4 (single-edge on B) count up on a rising edge of the chosen line that decodes as forward. They count down on a falling edge of that line that decodes as backward. All other transitions leave the count alone.
- R6: Function code 0 adds one and code 1 subtracts one for each line whose trigger code matches its edge. The trigger codes are 0 none, 1 rising, 2 falling and 3 both. When both lines qualify in the same cycle, the step is two.
- R7: Function code 2 (step/direction) counts only on rising edges of A: up when B is 1, down when B is 0. Line B never causes a step.
- R8: The pair {A,B} moving 00→10→11→01→00 is forward. In codes 3 to 7, every valid single-line transition loads dir_o with its decoded direction. In codes 0 to 2, dir_o takes the sign of each nonzero step.
- R9: In codes 3 to 7, a cycle in which both synchronized lines change leaves the count unchanged and sets err_o. err_o stays set until reset.
- R10: The count wraps modulo 2^WIDTH in both directions.
- R11: clear_i forces the count to 0 and has priority over load_i. load_i loads load_val_i. Either one overrides any count step in the same cycle.
- R12: While en_i is 0, no line transition changes count_o, dir_o or err_o.
- R13: Changing func_i never changes count_o by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_a_i | input | 1 | Asynchronous line A |
| sig_b_i | input | 1 | Asynchronous line B |
| func_i | input | 3 | Count function code |
| trig_a_i | input | 2 | Trigger code for line A (codes 0 and 1) |
| trig_b_i | input | 2 | Trigger code for line B (codes 0 and 1) |
| en_i | input | 1 | Count enable |
| clear_i | input | 1 | Synchronous clear of the count |
| load_i | input | 1 | Synchronous load of the count |
| load_val_i | input | WIDTH | Value for load |
| count_o | output | WIDTH | Position count |
| dir_o | output | 1 | Decoded direction, 1 = forward |
| level_a_o | output | 1 | Synchronized level of A |
| level_b_o | output | 1 | Synchronized level of B |
| err_o | output | 1 | Sticky invalid-transition flag |

## Verification
A line change driven between edges shows on the level outputs after the second rising edge. It shows on count_o, dir_o and err_o after the third. The bench therefore drives lines on a falling edge and samples three falling edges later, and one latency check samples after two edges to see the new level next to the old count. Clear and load act on the very next edge, so their checks sample one falling edge after the request.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [2:0] {
    FN_INC  = 3'd0,
    FN_DEC  = 3'd1,
    FN_PDIR = 3'd2,
    FN_X1A  = 3'd3,
    FN_X1B  = 3'd4,
    FN_X2A  = 3'd5,
    FN_X2B  = 3'd6,
    FN_X4   = 3'd7
  } func_e;

  typedef enum logic [1:0] {
    TR_NONE = 2'd0,
    TR_RISE = 2'd1,
    TR_FALL = 2'd2,
    TR_BOTH = 2'd3
  } trig_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned STEP_W      = 3;

  function automatic logic trig_hit(input logic [1:0] tr, input logic rise, input logic fall);
    unique case (trig_e'(tr))
      TR_RISE: trig_hit = rise;
      TR_FALL: trig_hit = fall;
      TR_BOTH: trig_hit = rise | fall;
      default: trig_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] cur_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], lines_i[g]};
    end
    assign cur_o[g]  = sh_q[STAGES-1];
    assign prev_o[g] = sh_q[STAGES];
  end
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
  import qcnt_pkg::*;
(
  input  logic [1:0]        cur_i,   // {a,b}
  input  logic [1:0]        prev_i,  // {a,b}
  input  logic [2:0]        func_i,
  input  logic [1:0]        trig_a_i,
  input  logic [1:0]        trig_b_i,
  input  logic              en_i,
  output logic [STEP_W-1:0] step_o,  // two's complement, -2..2
  output logic              dir_upd_o,
  output logic              dir_val_o,
  output logic              err_set_o
);
  logic a_ch, b_ch, a_rise, a_fall, b_rise, b_fall;
  logic single, both, fwd, quad;
  logic [1:0] mag;
  logic neg;

  assign a_ch   = cur_i[1] ^ prev_i[1];
  assign b_ch   = cur_i[0] ^ prev_i[0];
  assign a_rise = a_ch &  cur_i[1];
  assign a_fall = a_ch & ~cur_i[1];
  assign b_rise = b_ch &  cur_i[0];
  assign b_fall = b_ch & ~cur_i[0];
  assign single = a_ch ^ b_ch;
  assign both   = a_ch & b_ch;
  // A moving to differ from B, or B moving to match A, is forward
  assign fwd    = a_ch ? (cur_i[1] ^ cur_i[0]) : (cur_i[1] ~^ cur_i[0]);
  assign quad   = func_i >= 3'(FN_X1A);

  always_comb begin
    mag = 2'd0;
    neg = 1'b0;
    unique case (func_e'(func_i))
      FN_INC: mag = {1'b0, trig_hit(trig_a_i, a_rise, a_fall)} +
                    {1'b0, trig_hit(trig_b_i, b_rise, b_fall)};
      FN_DEC: begin
        mag = {1'b0, trig_hit(trig_a_i, a_rise, a_fall)} +
              {1'b0, trig_hit(trig_b_i, b_rise, b_fall)};
        neg = 1'b1;
      end
      FN_PDIR: begin
        mag = {1'b0, a_rise};
        neg = ~cur_i[0];
      end
      FN_X1A: begin
        mag = {1'b0, single & (fwd ? a_rise : a_fall)};
        neg = ~fwd;
      end
      FN_X1B: begin
        mag = {1'b0, single & (fwd ? b_rise : b_fall)};
        neg = ~fwd;
      end
      FN_X2A: begin
        mag = {1'b0, single & a_ch};
        neg = ~fwd;
      end
      FN_X2B: begin
        mag = {1'b0, single & b_ch};
        neg = ~fwd;
      end
      default: begin
        mag = {1'b0, single};
        neg = ~fwd;
      end
    endcase
    if (!en_i) mag = 2'd0;
  end

  assign step_o    = neg ? (STEP_W'(0) - {1'b0, mag}) : {1'b0, mag};
  assign dir_upd_o = en_i & (quad ? single : (mag != 2'd0));
  assign dir_val_o = quad ? fwd : ~neg;
  assign err_set_o = en_i & quad & both;
endmodule

// File: rtl/qcnt_accum.sv
module qcnt_accum
  import qcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  input  logic              dir_upd_i,
  input  logic              dir_val_i,
  input  logic              err_set_i,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WIDTH-1:0]  load_val_i,
  output logic [WIDTH-1:0]  count_o,
  output logic              dir_o,
  output logic              err_o
);
  localparam int unsigned EXT_W = WIDTH - STEP_W;

  logic [WIDTH-1:0] cnt_q, step_ext;
  logic dir_q, err_q;

  assign step_ext = {{EXT_W{step_i[STEP_W-1]}}, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      if (clear_i)     cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else             cnt_q <= cnt_q + step_ext;
      if (dir_upd_i) dir_q <= dir_val_i;
      if (err_set_i) err_q <= 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign err_o   = err_q;
endmodule

// File: rtl/qcnt_top.sv
module qcnt_top
  import qcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_a_i,
  input  logic             sig_b_i,
  input  logic [2:0]       func_i,
  input  logic [1:0]       trig_a_i,
  input  logic [1:0]       trig_b_i,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             dir_o,
  output logic             level_a_o,
  output logic             level_b_o,
  output logic             err_o
);
  logic [1:0] cur, prev;
  logic [STEP_W-1:0] step;
  logic dir_upd, dir_val, err_set;

  qcnt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines_i({sig_a_i, sig_b_i}),
    .cur_o  (cur),
    .prev_o (prev)
  );

  qcnt_decode u_dec (
    .cur_i    (cur),
    .prev_i   (prev),
    .func_i   (func_i),
    .trig_a_i (trig_a_i),
    .trig_b_i (trig_b_i),
    .en_i     (en_i),
    .step_o   (step),
    .dir_upd_o(dir_upd),
    .dir_val_o(dir_val),
    .err_set_o(err_set)
  );

  qcnt_accum #(.WIDTH(WIDTH)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .dir_upd_i (dir_upd),
    .dir_val_i (dir_val),
    .err_set_i (err_set),
    .clear_i   (clear_i),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .count_o   (count_o),
    .dir_o     (dir_o),
    .err_o     (err_o)
  );

  assign level_a_o = cur[1];
  assign level_b_o = cur[0];
endmodule

// File: rtl/qcnt_checker.sv
module qcnt_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       func_i,
  input logic             en_i,
  input logic             clear_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] count_o,
  input logic             err_o
);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_err_quad_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(func_i) >= 3'd3 && $past(en_i)));

  p_hold_disabled_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !clear_i) |=> count_o == $past(count_o));

  p_clear_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  p_load_value_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> count_o == $past(load_val_i));

  // step magnitude is at most two, wrapping allowed
  p_step_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i) |=> WIDTH'(count_o - $past(count_o) + WIDTH'(2)) <= WIDTH'(4));
endmodule

bind qcnt_top qcnt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .func_i    (func_i),
  .en_i      (en_i),
  .clear_i   (clear_i),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .count_o   (count_o),
  .err_o     (err_o)
);

// File: tb/qcnt_tb_top.sv
module qcnt_tb_top;
  localparam int W = 8;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa = 1'b0, sb = 1'b0;
  logic [2:0] func = 3'd7;
  logic [1:0] ta = 2'd0, tb = 2'd0;
  logic en = 1'b1, clr = 1'b0, ld = 1'b0;
  logic [W-1:0] ldv = '0;
  logic [W-1:0] count;
  logic dir, lva, lvb, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qcnt_top #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sig_a_i(sa), .sig_b_i(sb),
    .func_i(func), .trig_a_i(ta), .trig_b_i(tb), .en_i(en),
    .clear_i(clr), .load_i(ld), .load_val_i(ldv),
    .count_o(count), .dir_o(dir), .level_a_o(lva), .level_b_o(lvb), .err_o(err)
  );

  // {func, trig_a, trig_b, a, b, expected count, expected dir}
  localparam logic [17:0] VEC [NV] = '{
    {3'd7,2'd0,2'd0,1'b1,1'b0,8'd1,1'b1},
    {3'd7,2'd0,2'd0,1'b1,1'b1,8'd2,1'b1},
    {3'd7,2'd0,2'd0,1'b0,1'b1,8'd3,1'b1},
    {3'd7,2'd0,2'd0,1'b0,1'b0,8'd4,1'b1},
    {3'd7,2'd0,2'd0,1'b0,1'b1,8'd3,1'b0},
    {3'd7,2'd0,2'd0,1'b1,1'b1,8'd2,1'b0},
    {3'd5,2'd0,2'd0,1'b1,1'b0,8'd2,1'b0},
    {3'd5,2'd0,2'd0,1'b0,1'b0,8'd1,1'b0},
    {3'd5,2'd0,2'd0,1'b1,1'b0,8'd2,1'b1},
    {3'd3,2'd0,2'd0,1'b1,1'b1,8'd2,1'b1},
    {3'd3,2'd0,2'd0,1'b0,1'b1,8'd2,1'b1},
    {3'd3,2'd0,2'd0,1'b0,1'b0,8'd2,1'b1},
    {3'd3,2'd0,2'd0,1'b1,1'b0,8'd3,1'b1},
    {3'd3,2'd0,2'd0,1'b0,1'b0,8'd2,1'b0},
    {3'd4,2'd0,2'd0,1'b1,1'b0,8'd2,1'b1},
    {3'd4,2'd0,2'd0,1'b1,1'b1,8'd3,1'b1},
    {3'd4,2'd0,2'd0,1'b1,1'b0,8'd2,1'b0},
    {3'd6,2'd0,2'd0,1'b1,1'b1,8'd3,1'b1},
    {3'd6,2'd0,2'd0,1'b0,1'b1,8'd3,1'b1},
    {3'd6,2'd0,2'd0,1'b0,1'b0,8'd4,1'b1},
    {3'd0,2'd1,2'd0,1'b1,1'b0,8'd5,1'b1},
    {3'd0,2'd1,2'd0,1'b1,1'b1,8'd5,1'b1},
    {3'd0,2'd1,2'd0,1'b0,1'b1,8'd5,1'b1},
    {3'd0,2'd3,2'd2,1'b0,1'b0,8'd6,1'b1},
    {3'd0,2'd3,2'd2,1'b1,1'b1,8'd7,1'b1},
    {3'd0,2'd3,2'd2,1'b0,1'b0,8'd9,1'b1},
    {3'd1,2'd2,2'd3,1'b1,1'b0,8'd9,1'b1},
    {3'd1,2'd2,2'd3,1'b0,1'b1,8'd7,1'b0},
    {3'd2,2'd0,2'd0,1'b1,1'b1,8'd8,1'b1},
    {3'd2,2'd0,2'd0,1'b0,1'b0,8'd8,1'b1},
    {3'd2,2'd0,2'd0,1'b1,1'b0,8'd7,1'b0},
    {3'd2,2'd0,2'd0,1'b1,1'b1,8'd7,1'b0}
  };

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd7:       return "R3";
      3'd5, 3'd6: return "R4";
      3'd3, 3'd4: return "R5";
      3'd2:       return "R7";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive lines on a falling edge, then wait the three edges to the count
  task automatic move(input logic a, input logic b);
    @(negedge clk);
    sa = a; sb = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [W-1:0] v);
    @(negedge clk);
    ld = 1'b1; ldv = v;
    @(negedge clk);
    ld = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", 32'(count), 32'd0);
    chk("R1 dir", 32'(dir), 32'd1);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 levels", 32'({lva, lvb}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      @(negedge clk);
      func = v[17:15]; ta = v[14:13]; tb = v[12:11];
      sa = v[10]; sb = v[9];
      repeat (3) @(negedge clk);
      chk(tag_of(v[17:15]), 32'(count), 32'(v[8:1]));
      chk("R8 dir", 32'(dir), 32'(v[0]));
    end
    chk("R9 no err outside quad", 32'(err), 32'd0);

    // R2: level after two edges, count after three
    func = 3'd0; ta = 2'd1; tb = 2'd0;
    @(negedge clk);
    sa = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    sa = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 level a", 32'(lva), 32'd1);
    chk("R2 count not yet", 32'(count), 32'd7);
    @(negedge clk);
    chk("R2 count stepped", 32'(count), 32'd8);

    // R11 load, R10 wrap up
    pulse_load(8'hFF);
    chk("R11 load", 32'(count), 32'hFF);
    move(1'b0, sb);
    move(1'b1, sb);
    chk("R10 wrap up", 32'(count), 32'h00);

    // R10 wrap down
    func = 3'd1;
    move(1'b0, sb);
    move(1'b1, sb);
    chk("R10 wrap down", 32'(count), 32'hFF);

    // R12 disabled
    en = 1'b0; ta = 2'd3;
    move(1'b0, sb);
    move(1'b1, sb);
    chk("R12 count held", 32'(count), 32'hFF);
    chk("R12 dir held", 32'(dir), 32'd0);
    func = 3'd7;
    move(~sa, ~sb);
    chk("R12 err held", 32'(err), 32'd0);
    en = 1'b1;

    // R13 function change alone
    func = 3'd5;
    repeat (4) @(negedge clk);
    chk("R13 count kept", 32'(count), 32'hFF);

    // R9 double transition in four-edge mode
    func = 3'd7;
    move(~sa, ~sb);
    chk("R9 count unchanged", 32'(count), 32'hFF);
    chk("R9 err set", 32'(err), 32'd1);
    move(~sa, sb);
    chk("R9 err sticky", 32'(err), 32'd1);
    chk("R3 counts after err", 32'(count) == 32'h00 || 32'(count) == 32'hFE, 32'd1);

    // R11 clear over load, load over step
    @(negedge clk);
    clr = 1'b1; ld = 1'b1; ldv = 8'h05;
    @(negedge clk);
    clr = 1'b0; ld = 1'b0;
    chk("R11 clear priority", 32'(count), 32'd0);
    @(negedge clk);
    ld = 1'b1; ldv = 8'h42;
    sa = ~sa;
    repeat (4) @(negedge clk);
    ld = 1'b0;
    @(negedge clk);
    chk("R11 load over step", 32'(count), 32'h42);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule